// File: doc/BRIEF.md
# Fast Interrupt Bank with Private Vector

This block adds a bank of fast interrupt lines to the interrupt logic of a RISC-V style core, next to the standard machine interrupts. It keeps its own enable mask, a pending view that shows the live lines, and its own trap-vector base. None of these share storage with the standard machine interrupt registers. The core reaches these registers through a simple CSR access port.

On every cycle the block works out whether a fast interrupt can be taken. When several lines qualify, it picks the lowest-numbered one. It presents the core with a redirect address inside its private vector table. When the core accepts the interrupt, the block sends an acknowledge pulse with the interrupt number. An external platform interrupt controller uses that pulse to clear the source.

Top module: `fast_irq_ext`

## Requirements
- R1: There are NUM_IRQ (default 32) fast interrupt inputs. The enable mask sits at CSR address 0x7D0. It resets to zero, and reads return its value.
- R2: A write to the enable mask at 0x7D0 (csr_req_i=1, csr_we_i=1) changes the value read back from the next cycle on.
- R3: Reads of the pending view at CSR address 0x7D1 return the live `irq_i` lines. Writes to 0x7D1 have no effect on any register.
- R4: The vector base sits at CSR address 0x7D2. It is fully writable and resets to VEC_RESET (default 32'h0000_0001). This is the same value the standard machine trap vector resets to.
- R5: `take_o` is high in a cycle only if some line has its input high and its enable bit set, and `mie_i` is high.
- R6: When more than one line qualifies, `take_id_o` gives the lowest qualifying index.
- R7: `redirect_o` equals the vector base with bits [1:0] cleared, plus 4 × `take_id_o`.
- R8: `ack_o` is high, with `ack_id_o` equal to `take_id_o`, exactly in the cycles where `accept_i` and `take_o` are both high. In every other cycle it is low.
- R9: An access to any address other than 0x7D0, 0x7D1 or 0x7D2 raises `csr_illegal_o` in the same cycle. Such an access changes neither the enable mask nor the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Fast interrupt lines, active high |
| mie_i | input | 1 | Global machine interrupt enable |
| csr_req_i | input | 1 | CSR access valid |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_illegal_o | output | 1 | Access to an unknown address |
| take_o | output | 1 | A fast interrupt is ready to be taken |
| take_id_o | output | ID_W | Index of the interrupt to take |
| redirect_o | output | XLEN | Handler address for the core |
| accept_i | input | 1 | Core accepts the interrupt this cycle |
| ack_o | output | 1 | Acknowledge to the interrupt controller |
| ack_id_o | output | ID_W | Index being acknowledged |

## Verification
The assertions assume that `accept_i` is raised only in a cycle where `take_o` is high. They also assume the core holds the CSR address and the write strobe stable for the whole access cycle. The bench drives every input shortly after the falling edge. It raises `accept_i` only after it has seen `take_o` high. Its CSR accesses each last exactly one cycle, so every input stays inside those assumptions.

// File: rtl/fast_irq_pkg.sv
package fast_irq_pkg;
   localparam int unsigned CSR_AW = 12;
   localparam logic [CSR_AW-1:0] CSR_ENABLE  = 12'h7D0;
   localparam logic [CSR_AW-1:0] CSR_PENDING = 12'h7D1;
   localparam logic [CSR_AW-1:0] CSR_VECBASE = 12'h7D2;

   typedef enum logic [1:0] {
      SEL_NONE    = 2'd0,
      SEL_ENABLE  = 2'd1,
      SEL_PENDING = 2'd2,
      SEL_VECBASE = 2'd3
   } csr_sel_e;
endpackage

// File: rtl/fast_irq_csr.sv
module fast_irq_csr
   import fast_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQ   = 32,
   parameter int unsigned XLEN      = 32,
   parameter logic [31:0] VEC_RESET = 32'h0000_0001
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_IRQ-1:0]  irq_i,
   input  logic                csr_req_i,
   input  logic                csr_we_i,
   input  logic [CSR_AW-1:0]   csr_addr_i,
   input  logic [XLEN-1:0]     csr_wdata_i,
   output logic [XLEN-1:0]     csr_rdata_o,
   output logic                csr_illegal_o,
   output logic [NUM_IRQ-1:0]  enable_o,
   output logic [XLEN-1:0]     vecbase_o
);
   csr_sel_e           sel;
   logic [NUM_IRQ-1:0] enable_q;
   logic [XLEN-1:0]    vecbase_q;
   logic               wr_enable, wr_vecbase;

   always_comb begin
      unique case (csr_addr_i)
         CSR_ENABLE:  sel = SEL_ENABLE;
         CSR_PENDING: sel = SEL_PENDING;
         CSR_VECBASE: sel = SEL_VECBASE;
         default:     sel = SEL_NONE;
      endcase
   end

   assign csr_illegal_o = csr_req_i && (sel == SEL_NONE);
   assign wr_enable     = csr_req_i && csr_we_i && (sel == SEL_ENABLE);
   assign wr_vecbase    = csr_req_i && csr_we_i && (sel == SEL_VECBASE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enable_q  <= '0;
         vecbase_q <= XLEN'(VEC_RESET);
      end else begin
         if (wr_enable)  enable_q  <= csr_wdata_i[NUM_IRQ-1:0];
         if (wr_vecbase) vecbase_q <= csr_wdata_i;
      end
   end

   always_comb begin
      csr_rdata_o = '0;
      unique case (sel)
         SEL_ENABLE:  csr_rdata_o[NUM_IRQ-1:0] = enable_q;
         SEL_PENDING: csr_rdata_o[NUM_IRQ-1:0] = irq_i;
         SEL_VECBASE: csr_rdata_o = vecbase_q;
         default:     csr_rdata_o = '0;
      endcase
   end

   assign enable_o  = enable_q;
   assign vecbase_o = vecbase_q;

   // R9: an access to an unknown address leaves all stored state alone
   a_r9_unknown_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_we_i && csr_illegal_o) |=> ($stable(enable_q) && $stable(vecbase_q)));

   // R3: a write to the pending view does not reach the stored registers
   a_r3_pending_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_we_i && csr_addr_i == CSR_PENDING) |=> ($stable(enable_q) && $stable(vecbase_q)));

   // R2: the enable mask only changes after a write to its own address
   a_r2_enable_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(csr_req_i && csr_we_i && csr_addr_i == CSR_ENABLE) |=> $stable(enable_q));
endmodule

// File: rtl/fast_irq_prio.sv
module fast_irq_prio #(
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned ID_W    = 5
) (
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic [NUM_IRQ-1:0] enable_i,
   input  logic               mie_i,
   output logic               valid_o,
   output logic [ID_W-1:0]    id_o
);
   logic [NUM_IRQ-1:0] cand;

   // each line is qualified once, in a generated slice
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_qual
      assign cand[g] = irq_i[g] & enable_i[g] & mie_i;
   end

   // scan from the top down so that the lowest set index is left in id_o;
   // every line is visited exactly once
   always_comb begin
      id_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (cand[i]) id_o = ID_W'(i);
      end
   end

   assign valid_o = |cand;
endmodule

// File: rtl/fast_irq_vector.sv
module fast_irq_vector #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned ID_W = 5
) (
   input  logic [XLEN-1:0] vecbase_i,
   input  logic            valid_i,
   input  logic [ID_W-1:0] id_i,
   input  logic            accept_i,
   output logic [XLEN-1:0] redirect_o,
   output logic            ack_o,
   output logic [ID_W-1:0] ack_id_o
);
   localparam int unsigned SLOT_SHIFT = 2;

   logic [XLEN-1:0] base_aligned;
   logic [XLEN-1:0] offset;

   assign base_aligned = {vecbase_i[XLEN-1:SLOT_SHIFT], {SLOT_SHIFT{1'b0}}};
   assign offset       = XLEN'(id_i) << SLOT_SHIFT;
   assign redirect_o   = base_aligned + offset;

   assign ack_o    = accept_i & valid_i;
   assign ack_id_o = ack_o ? id_i : '0;
endmodule

// File: rtl/fast_irq_ext.sv
module fast_irq_ext
   import fast_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQ   = 32,
   parameter int unsigned XLEN      = 32,
   parameter logic [31:0] VEC_RESET = 32'h0000_0001,
   localparam int unsigned ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_IRQ-1:0]  irq_i,
   input  logic                mie_i,
   input  logic                csr_req_i,
   input  logic                csr_we_i,
   input  logic [CSR_AW-1:0]   csr_addr_i,
   input  logic [XLEN-1:0]     csr_wdata_i,
   output logic [XLEN-1:0]     csr_rdata_o,
   output logic                csr_illegal_o,
   output logic                take_o,
   output logic [ID_W-1:0]     take_id_o,
   output logic [XLEN-1:0]     redirect_o,
   input  logic                accept_i,
   output logic                ack_o,
   output logic [ID_W-1:0]     ack_id_o
);
   if (NUM_IRQ < 2 || NUM_IRQ > XLEN) begin : g_bad_num
      $error("fast_irq_ext: NUM_IRQ must lie in 2..XLEN");
   end
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("fast_irq_ext: XLEN must be 32 or 64");
   end

   logic [NUM_IRQ-1:0] enable;
   logic [XLEN-1:0]    vecbase;

   fast_irq_csr #(.NUM_IRQ(NUM_IRQ), .XLEN(XLEN), .VEC_RESET(VEC_RESET)) u_csr (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .irq_i         (irq_i),
      .csr_req_i     (csr_req_i),
      .csr_we_i      (csr_we_i),
      .csr_addr_i    (csr_addr_i),
      .csr_wdata_i   (csr_wdata_i),
      .csr_rdata_o   (csr_rdata_o),
      .csr_illegal_o (csr_illegal_o),
      .enable_o      (enable),
      .vecbase_o     (vecbase)
   );

   fast_irq_prio #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_prio (
      .irq_i    (irq_i),
      .enable_i (enable),
      .mie_i    (mie_i),
      .valid_o  (take_o),
      .id_o     (take_id_o)
   );

   fast_irq_vector #(.XLEN(XLEN), .ID_W(ID_W)) u_vec (
      .vecbase_i  (vecbase),
      .valid_i    (take_o),
      .id_i       (take_id_o),
      .accept_i   (accept_i),
      .redirect_o (redirect_o),
      .ack_o      (ack_o),
      .ack_id_o   (ack_id_o)
   );

   // R5: the chosen line is live and enabled
   a_r5_taken_line_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (irq_i[take_id_o] && enable[take_id_o] && mie_i));

   // R6: no lower qualifying line is skipped
   a_r6_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ((irq_i & enable & ((NUM_IRQ'(1) << take_id_o) - NUM_IRQ'(1))) == '0));

   // R7: handler addresses stay word aligned
   a_r7_redirect_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (redirect_o[1:0] == 2'b00));

   // R8: acknowledge only for an interrupt that is on offer, with its index
   a_r8_ack_needs_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> (take_o && ack_id_o == take_id_o));
endmodule

// File: tb/tb_fast_irq_ext.sv
module tb_fast_irq_ext;
   localparam int NIRQ = 32;
   localparam int XL   = 32;
   localparam int IDW  = 5;
   localparam logic [11:0] A_EN  = 12'h7D0;
   localparam logic [11:0] A_PND = 12'h7D1;
   localparam logic [11:0] A_VEC = 12'h7D2;
   localparam int NVEC = 7;

   // stimulus and expectation table: line pattern, enable mask, global enable,
   // expected take, expected index
   localparam logic [31:0] V_IRQ [NVEC] = '{32'h0000_0010, 32'h8000_0000, 32'h0000_0F00,
                                            32'h0000_0001, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0001_0040};
   localparam logic [31:0] V_EN  [NVEC] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0C00,
                                            32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0001_0000};
   localparam logic        V_MIE [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic        V_TK  [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [4:0]  V_ID  [NVEC] = '{5'd4, 5'd31, 5'd10, 5'd0, 5'd0, 5'd0, 5'd16};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NIRQ-1:0] irq = '0;
   logic mie = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic [11:0] addr = '0;
   logic [XL-1:0] wdata = '0;
   logic [XL-1:0] rdata;
   logic illegal, take, ack, accept = 1'b0;
   logic [IDW-1:0] take_id, ack_id;
   logic [XL-1:0] redirect;
   int checks = 0, errors = 0, cyc = 0;
   logic [XL-1:0] rd;

   always #2 clk = ~clk;

   fast_irq_ext dut (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mie_i(mie),
      .csr_req_i(req), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
      .csr_rdata_o(rdata), .csr_illegal_o(illegal),
      .take_o(take), .take_id_o(take_id), .redirect_o(redirect),
      .accept_i(accept), .ack_o(ack), .ack_id_o(ack_id)
   );

   task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      req = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R1, R4, R5)
      chk(take == 1'b0 && ack == 1'b0, "R5 no take in reset", {31'b0, take}, 32'h0);
      rst_n = 1'b1;
      csr_rd(A_EN, rd);  chk(rd == 32'h0, "R1 enable reset value", rd, 32'h0);
      csr_rd(A_VEC, rd); chk(rd == 32'h0000_0001, "R4 vector reset value", rd, 32'h0000_0001);

      // table walk (R5, R6, R7)
      for (int k = 0; k < NVEC; k++) begin
         csr_wr(A_EN, V_EN[k]);
         @(negedge clk);
         irq = V_IRQ[k]; mie = V_MIE[k];
         #1;
         chk(take == V_TK[k], $sformatf("R5 take row %0d", k), {31'b0, take}, {31'b0, V_TK[k]});
         if (V_TK[k]) begin
            chk(take_id == V_ID[k], $sformatf("R6 index row %0d", k), {27'b0, take_id}, {27'b0, V_ID[k]});
            chk(redirect == {25'b0, V_ID[k], 2'b00}, $sformatf("R7 redirect row %0d", k),
                redirect, {25'b0, V_ID[k], 2'b00});
         end
      end

      // R2: write lands on the next cycle
      irq = 32'h0000_0008; mie = 1'b1;
      csr_wr(A_EN, 32'h0);
      @(negedge clk); req = 1'b1; we = 1'b1; addr = A_EN; wdata = 32'h0000_0008;
      #1 chk(take == 1'b0, "R2 enable not yet applied", {31'b0, take}, 32'h0);
      @(negedge clk); req = 1'b0; we = 1'b0;
      #1 chk(take == 1'b1 && take_id == 5'd3, "R2 enable applied next cycle", {27'b0, take_id}, 32'd3);

      // R3: pending reads live lines, writes ignored
      irq = 32'h00A5_0000;
      csr_rd(A_PND, rd); chk(rd == 32'h00A5_0000, "R3 pending live", rd, 32'h00A5_0000);
      csr_wr(A_PND, 32'hFFFF_FFFF);
      csr_rd(A_PND, rd); chk(rd == 32'h00A5_0000, "R3 pending after write", rd, 32'h00A5_0000);
      csr_rd(A_EN, rd);  chk(rd == 32'h0000_0008, "R3 enable untouched by pending write", rd, 32'h8);
      csr_rd(A_VEC, rd); chk(rd == 32'h0000_0001, "R3 vector untouched by pending write", rd, 32'h1);

      // R4 and R7: new vector base with low bits set
      csr_wr(A_VEC, 32'h1000_0103);
      csr_rd(A_VEC, rd); chk(rd == 32'h1000_0103, "R4 vector readback", rd, 32'h1000_0103);
      irq = 32'h0000_0008;
      #1 chk(redirect == 32'h1000_010C, "R7 redirect with base", redirect, 32'h1000_010C);

      // R9: unknown address
      @(negedge clk); req = 1'b1; we = 1'b1; addr = 12'h7D3; wdata = 32'hDEAD_BEEF;
      #1 chk(illegal == 1'b1, "R9 illegal flag", {31'b0, illegal}, 32'h1);
      @(negedge clk); req = 1'b0; we = 1'b0;
      csr_rd(A_EN, rd);  chk(rd == 32'h0000_0008, "R9 enable unchanged", rd, 32'h8);
      csr_rd(A_VEC, rd); chk(rd == 32'h1000_0103, "R9 vector unchanged", rd, 32'h1000_0103);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = A_EN;
      #1 chk(illegal == 1'b0, "R9 no flag on known address", {31'b0, illegal}, 32'h0);
      @(negedge clk); req = 1'b0;

      // R8: acknowledge pulse
      #1 chk(ack == 1'b0, "R8 no ack without accept", {31'b0, ack}, 32'h0);
      if (take) begin
         @(negedge clk); accept = 1'b1;
         #1 chk(ack == 1'b1 && ack_id == 5'd3, "R8 ack with id", {27'b0, ack_id}, 32'd3);
         @(negedge clk); accept = 1'b0;
         #1 chk(ack == 1'b0, "R8 ack drops after accept", {31'b0, ack}, 32'h0);
      end else begin
         chk(1'b0, "R8 take missing before accept", {31'b0, take}, 32'h1);
      end
      mie = 1'b0;
      #1 chk(take == 1'b0, "R5 global enable masks", {31'b0, take}, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule